// File: doc/BRIEF.md
# Dual-Path Stall and Pinch Guard

This block watches a motorised drive while it runs and decides when the motion must end. It receives a signed motor-current sample stream with a valid strobe, a motor-bus voltage sample that travels on the same strobe, a position tick pulse, a motor-running flag and a two-bit operating-condition bucket select. From these it builds a few shared features: the rise between successive current samples, a count of consecutive samples above a plateau level, a count of sample periods without a position tick, and a flag recording an early bus sag.

Two decisions use these features at different speeds. A fast path flags a pinch when a steep current rise coincides with a halt in motion. It raises a release request and opens a lockout window in which motion must stay blocked. A slower path flags a stall when the current holds an elevated plateau for a longer confirmation count while motion has halted. It raises a stop request and opens a cool-down window before any retry. Neither path trips on current alone. A supply sag seen before any signature is reported under its own cause code. All thresholds come from a small register bank that holds one set per operating bucket, and the controller selects a set with the bucket input.

Top module: `stall_pinch_guard`

## Requirements
- R1: After reset all pulse, request and window outputs are low and the cause code reads 0 (none).
- R2: A pinch trip happens when both hold at once: at least the programmed pinch count of consecutive samples each exceeded the previous sample by more than the bucket's slope threshold, and no tick has arrived for the programmed stop count of sample periods. It gives a one-cycle pinch pulse, raises the release request and sets cause 1.
- R3: While position ticks keep arriving, no pinch or stall trip occurs, however steep or high the current is. A tick restarts the no-tick count.
- R4: A stall trip happens when at least the programmed stall count of consecutive samples lay strictly above the bucket's plateau threshold and motion has stopped (as in R2). It gives a one-cycle stall pulse, raises the stop request and sets cause 2. When both trips qualify in the same cycle, the pinch wins.
- R5: After a pinch trip, lockout_active is high for exactly the programmed lockout length in clock cycles. No trip is raised while it is high. The release request stays high until motor_run goes low.
- R6: After a stall trip, cooldown_active is high for exactly the programmed cool-down length in clock cycles. No trip is raised while it is high. The stop request stays high until motor_run goes low.
- R7: If a bus sample below the bucket's sag threshold arrives while no signature is present (no steep rise counted, no plateau counted, motion not stopped), a later trip in the same run reports cause 3 (supply sag) instead of 1 or 2.
- R8: Buckets are 0 cold, 1 hot, 2 low-voltage and 3 nominal. bucket_sel picks the threshold set used on every cycle. A write with cfg_addr[4] low stores into bucket cfg_addr[3:2], with field cfg_addr[1:0] = 0 for slope, 1 for plateau and 2 for sag. Addresses 16 to 21 hold, in order, the stop count, pinch count, stall count, blanking length, lockout length and cool-down length.
- R9: For the blanking length plus one clock cycles from the cycle motor_run rises, both detectors stay cleared and cannot trip.
- R10: The cause code holds its value until a write to address 22 clears it to 0. A trip in the same cycle as the clear takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| bucket_sel | input | 2 | Operating-condition bucket in use |
| cur_valid | input | 1 | Current and bus samples valid |
| cur_sample | input | CUR_W | Signed motor current sample |
| vbus_sample | input | VB_W | Motor-bus voltage sample |
| pos_tick | input | 1 | Position increment pulse |
| motor_run | input | 1 | Motor is being driven |
| pinch_pulse | output | 1 | One-cycle pinch trip |
| release_req | output | 1 | Request to reverse and release |
| stall_pulse | output | 1 | One-cycle stall trip |
| stop_req | output | 1 | Request to stop |
| lockout_active | output | 1 | Post-pinch lockout, motion blocked |
| cooldown_active | output | 1 | Post-stall cool-down, retry blocked |
| cause_code | output | 2 | 0 none, 1 pinch, 2 stall, 3 supply sag |

## Verification
The bench builds the block with its default widths: 12-bit current and voltage, 8-bit counters and 16-bit timers. It then programs small values: a stop count of 4, a pinch count of 2, a stall count of 6, lockout and cool-down lengths of 10 and 15, and blanking of 3, later raised to 40. With these values every trip, window and blanking interval completes within a few dozen cycles, and each one can be compared clock by clock against a behavioural model. The two buckets differ in plateau level, so the same current trace trips under one bucket and stays quiet under the other.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int NBUCKET = 4;
    localparam int ADDR_W  = 5;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PINCH = 2'd1,
        CAUSE_STALL = 2'd2,
        CAUSE_SAG   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOCK = 2'd1,
        ST_COOL = 2'd2
    } guard_st_e;

    localparam logic [1:0] FLD_SLOPE = 2'd0;
    localparam logic [1:0] FLD_PLAT  = 2'd1;
    localparam logic [1:0] FLD_SAG   = 2'd2;

    localparam logic [ADDR_W-1:0] A_STOP    = 5'd16;
    localparam logic [ADDR_W-1:0] A_PINCH_N = 5'd17;
    localparam logic [ADDR_W-1:0] A_STALL_N = 5'd18;
    localparam logic [ADDR_W-1:0] A_BLANK   = 5'd19;
    localparam logic [ADDR_W-1:0] A_LOCK    = 5'd20;
    localparam logic [ADDR_W-1:0] A_COOL    = 5'd21;
    localparam logic [ADDR_W-1:0] A_CLR     = 5'd22;
endpackage

// File: rtl/spg_cfg_bank.sv
module spg_cfg_bank
    import spg_pkg::*;
#(
    parameter int CUR_W     = 12,
    parameter int VB_W      = 12,
    parameter int CNT_W     = 8,
    parameter int TMR_W     = 16,
    parameter int DATA_W    = 16,
    parameter int DEF_SLOPE = 40,
    parameter int DEF_PLAT  = 600,
    parameter int DEF_SAG   = 1500,
    parameter int DEF_STOP  = 8,
    parameter int DEF_PN    = 3,
    parameter int DEF_SN    = 12,
    parameter int DEF_BLANK = 16,
    parameter int DEF_LOCK  = 64,
    parameter int DEF_COOL  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic [1:0]               bucket_sel,
    output logic signed [CUR_W-1:0]  slope_thr,
    output logic signed [CUR_W-1:0]  plat_thr,
    output logic [VB_W-1:0]          sag_thr,
    output logic [CNT_W-1:0]         stop_n,
    output logic [CNT_W-1:0]         pinch_n,
    output logic [CNT_W-1:0]         stall_n,
    output logic [TMR_W-1:0]         blank_len,
    output logic [TMR_W-1:0]         lock_len,
    output logic [TMR_W-1:0]         cool_len,
    output logic                     cause_clr
);
    typedef struct packed {
        logic [NBUCKET-1:0][CUR_W-1:0] slope;
        logic [NBUCKET-1:0][CUR_W-1:0] plat;
        logic [NBUCKET-1:0][VB_W-1:0]  sag;
        logic [CNT_W-1:0]              stop_n;
        logic [CNT_W-1:0]              pinch_n;
        logic [CNT_W-1:0]              stall_n;
        logic [TMR_W-1:0]              blank;
        logic [TMR_W-1:0]              lock;
        logic [TMR_W-1:0]              cool;
    } bank_s;

    localparam bank_s BANK_RST = '{
        slope:   {NBUCKET{CUR_W'(DEF_SLOPE)}},
        plat:    {NBUCKET{CUR_W'(DEF_PLAT)}},
        sag:     {NBUCKET{VB_W'(DEF_SAG)}},
        stop_n:  CNT_W'(DEF_STOP),
        pinch_n: CNT_W'(DEF_PN),
        stall_n: CNT_W'(DEF_SN),
        blank:   TMR_W'(DEF_BLANK),
        lock:    TMR_W'(DEF_LOCK),
        cool:    TMR_W'(DEF_COOL)
    };

    bank_s b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (cfg_we) begin
            if (!cfg_addr[4]) begin
                case (cfg_addr[1:0])
                    FLD_SLOPE: b_d.slope[cfg_addr[3:2]] = cfg_wdata[CUR_W-1:0];
                    FLD_PLAT:  b_d.plat[cfg_addr[3:2]]  = cfg_wdata[CUR_W-1:0];
                    FLD_SAG:   b_d.sag[cfg_addr[3:2]]   = cfg_wdata[VB_W-1:0];
                    default: ;
                endcase
            end else begin
                case (cfg_addr)
                    A_STOP:    b_d.stop_n  = cfg_wdata[CNT_W-1:0];
                    A_PINCH_N: b_d.pinch_n = cfg_wdata[CNT_W-1:0];
                    A_STALL_N: b_d.stall_n = cfg_wdata[CNT_W-1:0];
                    A_BLANK:   b_d.blank   = cfg_wdata[TMR_W-1:0];
                    A_LOCK:    b_d.lock    = cfg_wdata[TMR_W-1:0];
                    A_COOL:    b_d.cool    = cfg_wdata[TMR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= BANK_RST;
        else        b_q <= b_d;
    end

    assign slope_thr = $signed(b_q.slope[bucket_sel]);
    assign plat_thr  = $signed(b_q.plat[bucket_sel]);
    assign sag_thr   = b_q.sag[bucket_sel];
    assign stop_n    = b_q.stop_n;
    assign pinch_n   = b_q.pinch_n;
    assign stall_n   = b_q.stall_n;
    assign blank_len = b_q.blank;
    assign lock_len  = b_q.lock;
    assign cool_len  = b_q.cool;
    assign cause_clr = cfg_we && (cfg_addr == A_CLR);

    // R8
    bucket_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr[4] && cfg_addr[1:0] == FLD_PLAT)
            |=> (b_q.plat[$past(cfg_addr[3:2])] == $past(cfg_wdata[CUR_W-1:0])));
endmodule

// File: rtl/spg_features.sv
module spg_features #(
    parameter int CUR_W = 12,
    parameter int VB_W  = 12,
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cur_valid,
    input  logic signed [CUR_W-1:0] cur_sample,
    input  logic [VB_W-1:0]         vbus_sample,
    input  logic                    pos_tick,
    input  logic                    motor_run,
    input  logic                    hold,
    input  logic signed [CUR_W-1:0] slope_thr,
    input  logic signed [CUR_W-1:0] plat_thr,
    input  logic [VB_W-1:0]         sag_thr,
    input  logic [CNT_W-1:0]        stop_n,
    input  logic [TMR_W-1:0]        blank_len,
    output logic                    stopped,
    output logic [CNT_W-1:0]        rise_cnt,
    output logic [CNT_W-1:0]        plat_cnt,
    output logic                    sag_seen
);
    typedef struct packed {
        logic             run;
        logic [TMR_W-1:0] blank;
        logic [CNT_W-1:0] notick;
        logic [CUR_W-1:0] prev;
        logic             prev_v;
        logic [CNT_W-1:0] rcnt;
        logic [CNT_W-1:0] pcnt;
        logic             sag;
    } feat_s;

    feat_s f_d, f_q;
    logic det_en;
    logic steep, above;
    logic signed [CUR_W:0] diff;

    always_comb begin
        diff   = (CUR_W+1)'(cur_sample) - (CUR_W+1)'($signed(f_q.prev));
        steep  = f_q.prev_v && (diff > (CUR_W+1)'(slope_thr));
        above  = cur_sample > plat_thr;
        det_en = motor_run && f_q.run && (f_q.blank == '0) && !hold;

        f_d     = f_q;
        f_d.run = motor_run;
        if (motor_run && !f_q.run)  f_d.blank = blank_len;
        else if (f_q.blank != '0)   f_d.blank = f_q.blank - 1'b1;

        if (!det_en) begin
            f_d.notick = '0;
            f_d.prev_v = 1'b0;
            f_d.rcnt   = '0;
            f_d.pcnt   = '0;
            f_d.sag    = 1'b0;
        end else begin
            if (pos_tick)
                f_d.notick = '0;
            else if (cur_valid && f_q.notick != '1)
                f_d.notick = f_q.notick + 1'b1;
            if (cur_valid) begin
                f_d.prev   = cur_sample;
                f_d.prev_v = 1'b1;
                if (steep) f_d.rcnt = (f_q.rcnt == '1) ? f_q.rcnt : f_q.rcnt + 1'b1;
                else       f_d.rcnt = '0;
                if (above) f_d.pcnt = (f_q.pcnt == '1) ? f_q.pcnt : f_q.pcnt + 1'b1;
                else       f_d.pcnt = '0;
                if (vbus_sample < sag_thr && f_q.rcnt == '0 && f_q.pcnt == '0 && !stopped)
                    f_d.sag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign stopped  = f_q.notick >= stop_n;
    assign rise_cnt = f_q.rcnt;
    assign plat_cnt = f_q.pcnt;
    assign sag_seen = f_q.sag;

    // R9
    start_blank_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_run && !f_q.run) |=> (rise_cnt == '0 && plat_cnt == '0 && sag_seen == 1'b0));

    // R3
    tick_unstops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_tick |=> (!stopped || stop_n == '0));
endmodule

// File: rtl/spg_decide.sv
module spg_decide
    import spg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             motor_run,
    input  logic             stopped,
    input  logic [CNT_W-1:0] rise_cnt,
    input  logic [CNT_W-1:0] plat_cnt,
    input  logic             sag_seen,
    input  logic [CNT_W-1:0] pinch_n,
    input  logic [CNT_W-1:0] stall_n,
    input  logic [TMR_W-1:0] lock_len,
    input  logic [TMR_W-1:0] cool_len,
    input  logic             cause_clr,
    output logic             hold,
    output logic             pinch_pulse,
    output logic             release_req,
    output logic             stall_pulse,
    output logic             stop_req,
    output logic             lockout_active,
    output logic             cooldown_active,
    output logic [1:0]       cause_code
);
    typedef struct packed {
        guard_st_e        st;
        logic [TMR_W-1:0] tmr;
        logic             pp;
        logic             sp;
        logic             rel;
        logic             stp;
        cause_e           cause;
    } dec_s;

    dec_s d_d, d_q;
    logic armed, trip_p, trip_s;

    always_comb begin
        armed  = (d_q.st == ST_IDLE) && motor_run && stopped;
        trip_p = armed && (rise_cnt != '0) && (rise_cnt >= pinch_n);
        trip_s = armed && !trip_p && (plat_cnt != '0) && (plat_cnt >= stall_n);

        d_d    = d_q;
        d_d.pp = 1'b0;
        d_d.sp = 1'b0;
        if (!motor_run) begin
            d_d.rel = 1'b0;
            d_d.stp = 1'b0;
        end
        if (cause_clr) d_d.cause = CAUSE_NONE;
        if (d_q.st != ST_IDLE) begin
            if (d_q.tmr <= TMR_W'(1)) d_d.st = ST_IDLE;
            else                      d_d.tmr = d_q.tmr - 1'b1;
        end
        if (trip_p) begin
            d_d.pp    = 1'b1;
            d_d.rel   = 1'b1;
            d_d.st    = ST_LOCK;
            d_d.tmr   = lock_len;
            d_d.cause = sag_seen ? CAUSE_SAG : CAUSE_PINCH;
        end else if (trip_s) begin
            d_d.sp    = 1'b1;
            d_d.stp   = 1'b1;
            d_d.st    = ST_COOL;
            d_d.tmr   = cool_len;
            d_d.cause = sag_seen ? CAUSE_SAG : CAUSE_STALL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '{st: ST_IDLE, tmr: '0, pp: 1'b0, sp: 1'b0,
                             rel: 1'b0, stp: 1'b0, cause: CAUSE_NONE};
        else        d_q <= d_d;
    end

    assign hold            = d_q.st != ST_IDLE;
    assign pinch_pulse     = d_q.pp;
    assign release_req     = d_q.rel;
    assign stall_pulse     = d_q.sp;
    assign stop_req        = d_q.stp;
    assign lockout_active  = d_q.st == ST_LOCK;
    assign cooldown_active = d_q.st == ST_COOL;
    assign cause_code      = d_q.cause;

    // R2
    pinch_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pinch_pulse |-> $past(stopped && rise_cnt != '0));

    // R4
    stall_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pulse |-> $past(stopped && plat_cnt != '0));

    // R5
    no_trip_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_active || cooldown_active) |=> !(pinch_pulse || stall_pulse));

    // R10
    cause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pinch_pulse && !stall_pulse && !$past(cause_clr)) |-> $stable(cause_code));

    // R4
    one_trip_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pinch_pulse, stall_pulse}));
endmodule

// File: rtl/stall_pinch_guard.sv
module stall_pinch_guard
    import spg_pkg::*;
#(
    parameter int CUR_W  = 12,
    parameter int VB_W   = 12,
    parameter int CNT_W  = 8,
    parameter int TMR_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic [1:0]              bucket_sel,
    input  logic                    cur_valid,
    input  logic signed [CUR_W-1:0] cur_sample,
    input  logic [VB_W-1:0]         vbus_sample,
    input  logic                    pos_tick,
    input  logic                    motor_run,
    output logic                    pinch_pulse,
    output logic                    release_req,
    output logic                    stall_pulse,
    output logic                    stop_req,
    output logic                    lockout_active,
    output logic                    cooldown_active,
    output logic [1:0]              cause_code
);
    logic signed [CUR_W-1:0] slope_thr, plat_thr;
    logic [VB_W-1:0]         sag_thr;
    logic [CNT_W-1:0]        stop_n, pinch_n, stall_n, rise_cnt, plat_cnt;
    logic [TMR_W-1:0]        blank_len, lock_len, cool_len;
    logic                    cause_clr, hold, stopped, sag_seen;

    spg_cfg_bank #(.CUR_W(CUR_W), .VB_W(VB_W), .CNT_W(CNT_W), .TMR_W(TMR_W),
                   .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bucket_sel(bucket_sel),
        .slope_thr(slope_thr), .plat_thr(plat_thr), .sag_thr(sag_thr),
        .stop_n(stop_n), .pinch_n(pinch_n), .stall_n(stall_n),
        .blank_len(blank_len), .lock_len(lock_len), .cool_len(cool_len),
        .cause_clr(cause_clr)
    );

    spg_features #(.CUR_W(CUR_W), .VB_W(VB_W), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_feat (
        .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .cur_sample(cur_sample),
        .vbus_sample(vbus_sample), .pos_tick(pos_tick), .motor_run(motor_run),
        .hold(hold), .slope_thr(slope_thr), .plat_thr(plat_thr), .sag_thr(sag_thr),
        .stop_n(stop_n), .blank_len(blank_len), .stopped(stopped),
        .rise_cnt(rise_cnt), .plat_cnt(plat_cnt), .sag_seen(sag_seen)
    );

    spg_decide #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .motor_run(motor_run), .stopped(stopped),
        .rise_cnt(rise_cnt), .plat_cnt(plat_cnt), .sag_seen(sag_seen),
        .pinch_n(pinch_n), .stall_n(stall_n), .lock_len(lock_len),
        .cool_len(cool_len), .cause_clr(cause_clr), .hold(hold),
        .pinch_pulse(pinch_pulse), .release_req(release_req),
        .stall_pulse(stall_pulse), .stop_req(stop_req),
        .lockout_active(lockout_active), .cooldown_active(cooldown_active),
        .cause_code(cause_code)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pinch_pulse && !stall_pulse && cause_code == 2'd0) || !rst_n);
endmodule

// File: tb/stall_pinch_guard_test.sv
module stall_pinch_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0] bucket_sel = '0;
    logic cur_valid = 1'b0;
    logic signed [11:0] cur_sample = '0;
    logic [11:0] vbus_sample = '0;
    logic pos_tick = 1'b0;
    logic motor_run = 1'b0;
    logic pinch_pulse, release_req, stall_pulse, stop_req;
    logic lockout_active, cooldown_active;
    logic [1:0] cause_code;

    int n_chk = 0, n_fail = 0;
    int n_pinch = 0, n_stall = 0, n_lock = 0, n_cool = 0;

    always #10 clk = ~clk;

    stall_pinch_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bucket_sel(bucket_sel), .cur_valid(cur_valid),
        .cur_sample(cur_sample), .vbus_sample(vbus_sample), .pos_tick(pos_tick),
        .motor_run(motor_run), .pinch_pulse(pinch_pulse), .release_req(release_req),
        .stall_pulse(stall_pulse), .stop_req(stop_req),
        .lockout_active(lockout_active), .cooldown_active(cooldown_active),
        .cause_code(cause_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int ms_slope[4], ms_plat[4], ms_sag[4];
    int mc_stop, mc_pn, mc_sn, mc_blank, mc_lock, mc_cool;
    int m_run, m_blank, m_notick, m_prev, m_prevv, m_rc, m_pc, m_sag;
    int m_st, m_tmr, m_pp, m_sp, m_rel, m_stp, m_cause;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ms_slope[b]) begin
                ms_slope[b] = 40; ms_plat[b] = 600; ms_sag[b] = 1500;
            end
            mc_stop = 8; mc_pn = 3; mc_sn = 12; mc_blank = 16; mc_lock = 64; mc_cool = 128;
            m_run = 0; m_blank = 0; m_notick = 0; m_prev = 0; m_prevv = 0;
            m_rc = 0; m_pc = 0; m_sag = 0;
            m_st = 0; m_tmr = 0; m_pp = 0; m_sp = 0; m_rel = 0; m_stp = 0; m_cause = 0;
        end else begin
            int c, sl, pl, sg;
            bit stp_f, det, tp, ts, steep_f, above_f, sag_hit;
            c = cur_sample;
            sl = ms_slope[bucket_sel]; pl = ms_plat[bucket_sel]; sg = ms_sag[bucket_sel];
            stp_f = (m_notick >= mc_stop);
            det = motor_run && m_run != 0 && m_blank == 0 && m_st == 0;
            tp = m_st == 0 && motor_run && stp_f && m_rc > 0 && m_rc >= mc_pn;
            ts = !tp && m_st == 0 && motor_run && stp_f && m_pc > 0 && m_pc >= mc_sn;
            steep_f = m_prevv != 0 && (c - m_prev) > sl;
            above_f = c > pl;
            sag_hit = vbus_sample < sg && m_rc == 0 && m_pc == 0 && !stp_f;

            m_pp = tp; m_sp = ts;
            if (!motor_run) begin m_rel = 0; m_stp = 0; end
            if (cfg_we && cfg_addr == 22) m_cause = 0;
            if (m_st != 0) begin
                if (m_tmr <= 1) m_st = 0; else m_tmr--;
            end
            if (tp) begin
                m_rel = 1; m_st = 1; m_tmr = mc_lock; m_cause = m_sag ? 3 : 1;
            end else if (ts) begin
                m_stp = 1; m_st = 2; m_tmr = mc_cool; m_cause = m_sag ? 3 : 2;
            end

            if (!det) begin
                m_notick = 0; m_prevv = 0; m_rc = 0; m_pc = 0; m_sag = 0;
            end else begin
                if (pos_tick) m_notick = 0;
                else if (cur_valid && m_notick < 255) m_notick++;
                if (cur_valid) begin
                    m_prev = c; m_prevv = 1;
                    m_rc = steep_f ? ((m_rc < 255) ? m_rc + 1 : 255) : 0;
                    m_pc = above_f ? ((m_pc < 255) ? m_pc + 1 : 255) : 0;
                    if (sag_hit) m_sag = 1;
                end
            end
            if (motor_run && m_run == 0) m_blank = mc_blank;
            else if (m_blank > 0) m_blank--;
            m_run = motor_run;

            if (cfg_we) begin
                if (!cfg_addr[4]) begin
                    case (cfg_addr[1:0])
                        2'd0: ms_slope[cfg_addr[3:2]] = int'($signed(cfg_wdata[11:0]));
                        2'd1: ms_plat[cfg_addr[3:2]]  = int'($signed(cfg_wdata[11:0]));
                        2'd2: ms_sag[cfg_addr[3:2]]   = int'(cfg_wdata[11:0]);
                        default: ;
                    endcase
                end else begin
                    case (cfg_addr)
                        5'd16: mc_stop  = cfg_wdata[7:0];
                        5'd17: mc_pn    = cfg_wdata[7:0];
                        5'd18: mc_sn    = cfg_wdata[7:0];
                        5'd19: mc_blank = cfg_wdata;
                        5'd20: mc_lock  = cfg_wdata;
                        5'd21: mc_cool  = cfg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison and event counting
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 pinch_pulse vs model", pinch_pulse, m_pp);
            chk("R5 release_req vs model", release_req, m_rel);
            chk("R4 stall_pulse vs model", stall_pulse, m_sp);
            chk("R6 stop_req vs model", stop_req, m_stp);
            chk("R5 lockout_active vs model", lockout_active, m_st == 1);
            chk("R6 cooldown_active vs model", cooldown_active, m_st == 2);
            chk("R10 cause_code vs model", cause_code, m_cause);
            if (pinch_pulse) n_pinch++;
            if (stall_pulse) n_stall++;
            if (lockout_active) n_lock++;
            if (cooldown_active) n_cool++;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic smp(input int c, input int vb, input bit tick);
        @(negedge clk);
        cur_valid = 1'b1; cur_sample = 12'(c); vbus_sample = 12'(vb); pos_tick = tick;
        @(negedge clk);
        cur_valid = 1'b0; pos_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic zero_counts();
        n_pinch = 0; n_stall = 0; n_lock = 0; n_cool = 0;
    endtask

    task automatic start_run();
        @(negedge clk); motor_run = 1'b1;
        idle(6);
    endtask

    task automatic end_run();
        @(negedge clk); motor_run = 1'b0;
        idle(2);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        chk("R1 pinch_pulse at reset", pinch_pulse, 0);
        chk("R1 stall_pulse at reset", stall_pulse, 0);
        chk("R1 lockout at reset", lockout_active, 0);
        chk("R1 cooldown at reset", cooldown_active, 0);
        chk("R1 cause at reset", cause_code, 0);
        rst_n = 1'b1;
        idle(2);

        // R8 programming: bucket 0 cold, bucket 1 hot
        wr(0, 20); wr(1, 300); wr(2, 1000);
        wr(4, 60); wr(5, 500); wr(6, 1000);
        wr(16, 4); wr(17, 2); wr(18, 6); wr(19, 3); wr(20, 10); wr(21, 15);

        // R3 steep and high current with ticks: no trip; then R2 pinch once ticks stop
        bucket_sel = 2'd0; zero_counts();
        start_run();
        for (int k = 0; k < 10; k++) smp(100 + 50 * k, 3000, 1'b1);
        chk("R3 no pinch while ticking", n_pinch, 0);
        chk("R3 no stall while ticking", n_stall, 0);
        for (int k = 10; k < 15; k++) smp(100 + 50 * k, 3000, 1'b0);
        idle(25);
        chk("R2 one pinch pulse", n_pinch, 1);
        chk("R4 pinch wins over stall", n_stall, 0);
        chk("R2 cause pinch", cause_code, 1);
        chk("R5 lockout length", n_lock, 10);
        chk("R5 release held while running", release_req, 1);
        end_run();
        chk("R5 release drops with motor_run", release_req, 0);

        // R4 stall on flat plateau, R6 cool-down
        zero_counts();
        start_run();
        for (int k = 0; k < 8; k++) smp(400, 3000, 1'b0);
        idle(25);
        chk("R4 one stall pulse", n_stall, 1);
        chk("R4 no pinch on flat plateau", n_pinch, 0);
        chk("R4 cause stall", cause_code, 2);
        chk("R6 cool-down length", n_cool, 15);
        chk("R6 stop held while running", stop_req, 1);
        end_run();
        chk("R6 stop drops with motor_run", stop_req, 0);
        chk("R10 cause held after run", cause_code, 2);
        wr(22, 0);
        idle(1);
        chk("R10 cause cleared by write", cause_code, 0);

        // R7 early sag reclassifies the stall
        zero_counts();
        start_run();
        smp(100, 500, 1'b1);
        for (int k = 0; k < 8; k++) smp(400, 3000, 1'b0);
        idle(25);
        chk("R7 stall after sag", n_stall, 1);
        chk("R7 cause supply sag", cause_code, 3);
        end_run();
        wr(22, 0);

        // R8 hot bucket has higher plateau: 400 stays quiet, 600 trips
        bucket_sel = 2'd1; zero_counts();
        start_run();
        for (int k = 0; k < 10; k++) smp(400, 3000, 1'b0);
        idle(4);
        chk("R8 hot bucket below plateau quiet", n_stall, 0);
        chk("R8 cause still none", cause_code, 0);
        end_run();
        start_run();
        for (int k = 0; k < 8; k++) smp(600, 3000, 1'b0);
        idle(25);
        chk("R8 hot bucket above plateau trips", n_stall, 1);
        end_run();
        wr(22, 0);

        // R9 long blanking hides the same trace that stalls otherwise
        bucket_sel = 2'd0; wr(19, 40); zero_counts();
        @(negedge clk); motor_run = 1'b1;
        for (int k = 0; k < 12; k++) smp(400, 3000, 1'b0);
        chk("R9 no stall during blanking", n_stall, 0);
        chk("R9 no pinch during blanking", n_pinch, 0);
        end_run();

        idle(4);
        summary();
        $finish;
    end
endmodule